// File: doc/BRIEF.md
# Exception-Return Status Shift Unit

This unit computes the processor status word that takes effect when a return-from-exception or return-from-NMI instruction retires. The status word keeps a small stack of saved mode fields. A return pops that stack by moving the saved field down ten places, and then applies the flag rules for the return type. If the mode that is restored is user mode, the unit also exchanges the stack pointers. The live pointer goes to the kernel-save register, and the user stack pointer becomes the live pointer.

The pipeline issues a one-cycle command with a type bit, together with the present status word, stack pointer and user stack pointer. One clock later the unit presents the new status word, the stack-pointer values and a kernel-save write enable, along with a one-cycle completion strobe. These registered results stay unchanged until the next command.

Top module: `ers_shift_unit`

## Requirements
- R1: Bits 31:30 of the new status equal bits 31:30 of the input status. The one exception is bit 30 on an NMI return (see R6).
- R2: New status bits 17:0 equal input bits 27:10. New status bits 29:18 are zero. Bit 7 is the one exception (see R5).
- R3: When input bit 16 is set, the unit sets the kernel-save write enable. In that case the kernel-save value equals the input stack pointer, and the output stack pointer equals the user stack pointer. Input bit 16 becomes the user-mode flag, bit 6, after the shift.
- R4: When input bit 16 is clear, the kernel-save write enable is low. In that case the kernel-save value is zero, and the output stack pointer equals the input stack pointer.
- R5: When input bit 8 is clear, new status bit 7 is set. When input bit 8 is set, new bit 7 equals input bit 17. Input bit 8 is the pre-shift restart flag and bit 7 is the permit flag. The rule is the same for both return types.
- R6: An NMI return (type = 1) sets new status bit 30. An exception return (type = 0) leaves bit 30 equal to input bit 30.
- R7: All results appear in the clock cycle after the command, together with a one-cycle done pulse. The results hold while no command is issued.
- R8: After reset, done, every status bit, the kernel-save enable and both pointer outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ret_valid | input | 1 | One-cycle return command |
| ret_is_nmi | input | 1 | 1 = return from NMI, 0 = return from exception |
| status_in | input | 32 | Status word before the return |
| sp_in | input | 32 | Current stack pointer |
| usp_in | input | 32 | User stack pointer |
| done | output | 1 | Results valid strobe |
| status_out | output | 32 | New status word |
| sp_out | output | 32 | New stack pointer |
| ksp_wr | output | 1 | Kernel-save register write enable |
| ksp_out | output | 32 | Value for the kernel-save register |

## Verification
The bench drives a walking one through every status bit for both return types, so it catches any error in where bits land. A shift of the wrong amount, failing to clear bits 29:28, or letting bits 27:18 leak through all show up as a miscompare on a single bit. Further pseudo-random words combine the restart flag with the incoming permit bit. A design that reads the restart flag after the shift, or that overwrites bit 7 in both cases, then fails R5. Vectors with bit 16 set and clear would expose a design that tests the user flag before the shift (bit 6), or one that swaps the pointers unconditionally. Idle cycles between commands show whether done stays high, or the outputs drift, while no command is issued.

// File: rtl/ers_pkg.sv
package ers_pkg;
  parameter int unsigned ERS_DW        = 32;
  parameter int unsigned ERS_KEEP_BITS = 2;
  parameter int unsigned ERS_SAVE_BITS = 28;
  parameter int unsigned ERS_POP_SHIFT = 10;
  parameter int unsigned ERS_U_POS     = 6;
  parameter int unsigned ERS_P_POS     = 7;
  parameter int unsigned ERS_R_POS     = 8;
  parameter int unsigned ERS_M_POS     = 30;

  typedef enum logic {
    RET_EXC = 1'b0,
    RET_NMI = 1'b1
  } ret_kind_e;
endpackage

// File: rtl/ers_pop.sv
module ers_pop #(
  parameter int unsigned DW        = 32,
  parameter int unsigned KEEP_BITS = 2,
  parameter int unsigned SAVE_BITS = 28,
  parameter int unsigned POP_SHIFT = 10
) (
  input  logic [DW-1:0] status_i,
  output logic [DW-1:0] popped_o
);
  localparam int unsigned KEEP_LO = DW - KEEP_BITS;

  for (genvar i = 0; i < DW; i++) begin : g_bit
    if (i >= KEEP_LO) begin : g_keep
      assign popped_o[i] = status_i[i];
    end else if (i + POP_SHIFT < SAVE_BITS) begin : g_move
      assign popped_o[i] = status_i[i + POP_SHIFT];
    end else begin : g_zero
      assign popped_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/ers_flag_fix.sv
module ers_flag_fix #(
  parameter int unsigned DW    = 32,
  parameter int unsigned P_POS = 7,
  parameter int unsigned R_POS = 8,
  parameter int unsigned M_POS = 30
) (
  input  logic [DW-1:0] pre_i,
  input  logic [DW-1:0] popped_i,
  input  logic          is_nmi_i,
  output logic [DW-1:0] status_o
);
  logic restart_seen;

  always_comb begin
    restart_seen = pre_i[R_POS];
    status_o     = popped_i;
    if (!restart_seen) begin
      status_o[P_POS] = 1'b1;
    end
    if (is_nmi_i) begin
      status_o[M_POS] = 1'b1;
    end
  end
endmodule

// File: rtl/ers_stack_sel.sv
module ers_stack_sel #(
  parameter int unsigned DW    = 32,
  parameter int unsigned U_POS = 6
) (
  input  logic [DW-1:0] popped_i,
  input  logic [DW-1:0] sp_i,
  input  logic [DW-1:0] usp_i,
  output logic          swap_o,
  output logic [DW-1:0] sp_o,
  output logic [DW-1:0] ksp_o
);
  always_comb begin
    swap_o = popped_i[U_POS];
    if (swap_o) begin
      sp_o  = usp_i;
      ksp_o = sp_i;
    end else begin
      sp_o  = sp_i;
      ksp_o = '0;
    end
  end
endmodule

// File: rtl/ers_shift_unit.sv
module ers_shift_unit
  import ers_pkg::*;
#(
  parameter int unsigned DW        = ERS_DW,
  parameter int unsigned KEEP_BITS = ERS_KEEP_BITS,
  parameter int unsigned SAVE_BITS = ERS_SAVE_BITS,
  parameter int unsigned POP_SHIFT = ERS_POP_SHIFT,
  parameter int unsigned U_POS     = ERS_U_POS,
  parameter int unsigned P_POS     = ERS_P_POS,
  parameter int unsigned R_POS     = ERS_R_POS,
  parameter int unsigned M_POS     = ERS_M_POS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ret_valid,
  input  logic          ret_is_nmi,
  input  logic [DW-1:0] status_in,
  input  logic [DW-1:0] sp_in,
  input  logic [DW-1:0] usp_in,
  output logic          done,
  output logic [DW-1:0] status_out,
  output logic [DW-1:0] sp_out,
  output logic          ksp_wr,
  output logic [DW-1:0] ksp_out
);
  logic [DW-1:0] popped;
  logic [DW-1:0] status_nx;
  logic [DW-1:0] sp_nx;
  logic [DW-1:0] ksp_nx;
  logic          swap_nx;
  ret_kind_e     kind;

  assign kind = ret_kind_e'(ret_is_nmi);

  ers_pop #(
    .DW(DW), .KEEP_BITS(KEEP_BITS), .SAVE_BITS(SAVE_BITS), .POP_SHIFT(POP_SHIFT)
  ) u_pop (
    .status_i (status_in),
    .popped_o (popped)
  );

  ers_flag_fix #(
    .DW(DW), .P_POS(P_POS), .R_POS(R_POS), .M_POS(M_POS)
  ) u_flags (
    .pre_i    (status_in),
    .popped_i (popped),
    .is_nmi_i (kind == RET_NMI),
    .status_o (status_nx)
  );

  ers_stack_sel #(
    .DW(DW), .U_POS(U_POS)
  ) u_stack (
    .popped_i (popped),
    .sp_i     (sp_in),
    .usp_i    (usp_in),
    .swap_o   (swap_nx),
    .sp_o     (sp_nx),
    .ksp_o    (ksp_nx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0;
    end else begin
      done <= ret_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_out <= '0;
      sp_out     <= '0;
      ksp_wr     <= 1'b0;
      ksp_out    <= '0;
    end else if (ret_valid) begin
      status_out <= status_nx;
      sp_out     <= sp_nx;
      ksp_wr     <= swap_nx;
      ksp_out    <= ksp_nx;
    end
  end
endmodule

// File: rtl/ers_shift_unit_chk.sv
module ers_shift_unit_chk #(
  parameter int unsigned DW        = 32,
  parameter int unsigned POP_SHIFT = 10,
  parameter int unsigned U_POS     = 6,
  parameter int unsigned P_POS     = 7,
  parameter int unsigned R_POS     = 8,
  parameter int unsigned M_POS     = 30
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ret_valid,
  input logic          ret_is_nmi,
  input logic [DW-1:0] status_in,
  input logic [DW-1:0] sp_in,
  input logic [DW-1:0] usp_in,
  input logic          done,
  input logic [DW-1:0] status_out,
  input logic [DW-1:0] sp_out,
  input logic          ksp_wr,
  input logic [DW-1:0] ksp_out
);
  a_r7_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |=> done);
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    !ret_valid |=> !done);
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ret_valid |=> $stable(status_out) && $stable(sp_out) && $stable(ksp_out));
  a_r1_top_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |=> status_out[DW-1] == $past(status_in[DW-1]));
  a_r6_nmi_sets_m: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid && ret_is_nmi |=> status_out[M_POS]);
  a_r5_permit_set: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid && !status_in[R_POS] |=> status_out[P_POS]);
  a_r3_swap: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid && status_in[U_POS+POP_SHIFT] |=> ksp_wr && ksp_out == $past(sp_in)
      && sp_out == $past(usp_in));
  a_r4_no_swap: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid && !status_in[U_POS+POP_SHIFT] |=> !ksp_wr && sp_out == $past(sp_in));
endmodule

bind ers_shift_unit ers_shift_unit_chk #(
  .DW(DW), .POP_SHIFT(POP_SHIFT), .U_POS(U_POS),
  .P_POS(P_POS), .R_POS(R_POS), .M_POS(M_POS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_is_nmi(ret_is_nmi),
  .status_in(status_in), .sp_in(sp_in), .usp_in(usp_in), .done(done),
  .status_out(status_out), .sp_out(sp_out), .ksp_wr(ksp_wr), .ksp_out(ksp_out)
);

// File: tb/sim_ers_shift_unit.sv
module sim_ers_shift_unit;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ret_valid = 1'b0;
  logic        ret_is_nmi = 1'b0;
  logic [31:0] status_in = '0;
  logic [31:0] sp_in = '0;
  logic [31:0] usp_in = '0;
  logic        done;
  logic [31:0] status_out;
  logic [31:0] sp_out;
  logic        ksp_wr;
  logic [31:0] ksp_out;

  int vectors = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ers_shift_unit u0 (
    .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_is_nmi(ret_is_nmi),
    .status_in(status_in), .sp_in(sp_in), .usp_in(usp_in), .done(done),
    .status_out(status_out), .sp_out(sp_out), .ksp_wr(ksp_wr), .ksp_out(ksp_out)
  );

  function automatic logic [31:0] model_status(logic [31:0] s, logic nmi);
    logic [31:0] r;
    r = {s[31:30], 12'b0, s[27:10]};   // R1, R2
    if (!s[8]) r[7] = 1'b1;            // R5
    if (nmi)   r[30] = 1'b1;           // R6
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(logic [31:0] s, logic nmi, logic [31:0] sp, logic [31:0] usp);
    logic swp;
    @(negedge clk);
    ret_valid = 1'b1; ret_is_nmi = nmi; status_in = s; sp_in = sp; usp_in = usp;
    @(negedge clk);
    ret_valid = 1'b0; status_in = ~s; sp_in = ~sp; usp_in = ~usp;
    swp = s[16];
    chk("R7 done", {31'b0, done}, 32'd1);
    chk("R1 R2 R5 R6 status", status_out, model_status(s, nmi));
    if (swp) begin
      chk("R3 ksp_wr", {31'b0, ksp_wr}, 32'd1);
      chk("R3 ksp_out", ksp_out, sp);
      chk("R3 sp_out", sp_out, usp);
    end else begin
      chk("R4 ksp_wr", {31'b0, ksp_wr}, 32'd0);
      chk("R4 ksp_out", ksp_out, 32'd0);
      chk("R4 sp_out", sp_out, sp);
    end
    @(negedge clk);
    chk("R7 done drops", {31'b0, done}, 32'd0);
    chk("R7 status holds", status_out, model_status(s, nmi));
    chk("R7 sp holds", sp_out, swp ? usp : sp);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] x;
    repeat (3) @(negedge clk);
    chk("R8 done", {31'b0, done}, 32'd0);
    chk("R8 status", status_out, 32'd0);
    chk("R8 sp", sp_out, 32'd0);
    chk("R8 ksp_wr", {31'b0, ksp_wr}, 32'd0);
    chk("R8 ksp", ksp_out, 32'd0);
    rst_n = 1'b1;
    for (int n = 0; n < 2; n++) begin
      for (int b = 0; b < 32; b++) begin
        apply(32'h1 << b, n[0], 32'h1000_0000 + b, 32'h2000_0000 + b);
        apply(~(32'h1 << b), n[0], 32'hA000_0000 + b, 32'hB000_0000 + b);
      end
    end
    x = 32'h1234_5679;
    for (int k = 0; k < 400; k++) begin
      x ^= x << 13; x ^= x >> 17; x ^= x << 5;
      apply(x, x[3], x ^ 32'h5555_0000, ~x);
    end
    apply(32'hFFFF_FFFF, 1'b0, 32'h1, 32'h2);
    apply(32'h0000_0000, 1'b1, 32'h3, 32'h4);
    apply(32'h0001_0100, 1'b0, 32'h5, 32'h6);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule